// File: doc/BRIEF.md
# ADC Input Multiplexer Frame Sequencer

This block steps an ADC input multiplexer through a frame of time slots whose length software sets from one to ten. Every slot lasts a fixed number of 32768 Hz ticks. While a slot is active the block drives a 4-bit signal-select code to the analog multiplexer. It also emits a conversion-start strobe for the filter at every slot change and a pass-launch strobe for the compute engine at every frame start. When chopping is enabled, it toggles a chop-phase line once per frame.

Each slot has two programmed selections, one used in normal frames and one used in alternate frames. A processor asks for an alternate frame by raising a request bit at any time. The block notes the rising edge in a sticky flag and lets the current frame finish. It then runs exactly one alternate frame and returns to normal frames. During an alternate frame, slots whose normal code is marked as a phase-voltage input keep that normal code, so that voltage tracking downstream is never interrupted. The battery-monitor code enables the monitor only while the monitor enable bit is set.

Top module: `mux_frame_seq`

## Requirements
- R1: The effective slot count is `slot_count` clamped to the range 1..10: a value of 0 acts as 1 and a value above 10 acts as 10. `slot_idx` reports the active slot numbered from 1.
- R2: After reset, and at every frame start, the active slot is 1. The slot advances by one after 4 asserted ticks (TICKS_PER_SLOT). After the last slot it wraps to slot 1 of a new frame.
- R3: Slot k (1-based) takes its normal code from `norm_sel[4k-1:4k-4]` and its alternate code from `alt_sel[4k-1:4k-4]`. In a normal frame, `sel_code` is the normal code of the active slot.
- R4: A rising edge of `alt_req` does not change the frame in progress. The next frame after it is an alternate frame (`alt_frame`=1), and the frame after that is normal again. This holds even if `alt_req` falls on the very next clock or stays high. An edge seen in the same clock as a frame start counts toward the frame after.
- R5: A rising edge of `alt_req` seen during an alternate frame queues one more alternate frame, which follows immediately.
- R6: In an alternate frame, a slot whose normal code has its bit set in VOLT_MASK keeps its normal code. The default mask marks codes 1, 3 and 5. All other slots output their alternate code.
- R7: `frame_start` is high for exactly the one clock in which slot 1 of a new frame first appears. `fir_start` is high for the one clock in which any new slot appears, including slot 1 after a wrap.
- R8: `chop_phase` resets to 0. It toggles at each frame start while `chop_en` is high and holds its value otherwise.
- R9: `bat_en` is high only while `sel_code` equals the battery code 9 and `bat_mon_en` is high.
- R10: Without asserted ticks, the slot, the strobes and the frame type do not change.
- R11: Reset gives slot 1, a normal frame, `chop_phase`=0, both strobes low and no pending alternate request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32768 Hz enable, one clock wide |
| slot_count | input | 4 | Slots per frame, clamped to 1..10 |
| norm_sel | input | 40 | Normal selection codes, 4 bits per slot, slot 1 in the low bits |
| alt_sel | input | 40 | Alternate selection codes, same layout |
| alt_req | input | 1 | Alternate-frame request; its rising edge counts |
| chop_en | input | 1 | Enable per-frame chop toggling |
| bat_mon_en | input | 1 | Battery-monitor enable |
| sel_code | output | 4 | Signal-select code of the active slot |
| slot_idx | output | 4 | Active slot, numbered from 1 |
| alt_frame | output | 1 | Current frame is an alternate frame |
| frame_start | output | 1 | Compute-engine pass launch strobe |
| fir_start | output | 1 | Filter conversion start strobe |
| chop_phase | output | 1 | Chop phase |
| bat_en | output | 1 | Battery-monitor enable for the active slot |

## Verification
The hardest case to reach is a second alternate request that arrives while an alternate frame is already running, because it must be captured and queued instead of being merged into the frame in progress. The bench gets there by completing one alternate frame first. It then raises the request again while slot 1 of that alternate frame is active and walks the slots through two further frame boundaries. A related case is a request that is dropped one clock after it rises. The bench produces it with a single-clock pulse in the middle of a normal frame and checks that the deferred alternate frame still follows.

// File: rtl/mux_frame_seq.sv
module mux_frame_seq #(
  parameter int NSLOT = 10,
  parameter int CODE_W = 4,
  parameter int TICKS_PER_SLOT = 4,
  parameter logic [2**CODE_W-1:0] VOLT_MASK = 16'h002A,
  parameter logic [CODE_W-1:0] BAT_CODE = 4'd9,
  localparam int SW = $clog2(NSLOT+1),
  localparam int TW = $clog2(TICKS_PER_SLOT+1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [SW-1:0]           slot_count,
  input  logic [NSLOT*CODE_W-1:0] norm_sel,
  input  logic [NSLOT*CODE_W-1:0] alt_sel,
  input  logic                    alt_req,
  input  logic                    chop_en,
  input  logic                    bat_mon_en,
  output logic [CODE_W-1:0]       sel_code,
  output logic [SW-1:0]           slot_idx,
  output logic                    alt_frame,
  output logic                    frame_start,
  output logic                    fir_start,
  output logic                    chop_phase,
  output logic                    bat_en
);
  logic [SW-1:0] slot_r, eff;
  logic [TW-1:0] tcnt;
  logic req_q, pend, alt_r, chop_r, fs_r, fir_r;
  logic [CODE_W-1:0] nsel [NSLOT];
  logic [CODE_W-1:0] asel [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_unpack
    assign nsel[i] = norm_sel[i*CODE_W +: CODE_W];
    assign asel[i] = alt_sel[i*CODE_W +: CODE_W];
  end

  always_comb begin
    if (slot_count == '0)               eff = SW'(1);
    else if (slot_count > SW'(NSLOT))   eff = SW'(NSLOT);
    else                                eff = slot_count;
  end

  wire slot_end = tick && (tcnt == TW'(TICKS_PER_SLOT-1));
  wire at_last  = (slot_r >= eff - SW'(1));
  wire req_rise = alt_req && !req_q;
  wire [CODE_W-1:0] code_n = nsel[slot_r];
  wire [CODE_W-1:0] code_a = asel[slot_r];
  wire keep_n = VOLT_MASK[code_n];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_r <= '0;
      tcnt   <= '0;
      req_q  <= 1'b0;
      pend   <= 1'b0;
      alt_r  <= 1'b0;
      chop_r <= 1'b0;
      fs_r   <= 1'b0;
      fir_r  <= 1'b0;
    end else begin
      req_q <= alt_req;
      fs_r  <= 1'b0;
      fir_r <= 1'b0;
      if (req_rise) pend <= 1'b1;
      if (tick) tcnt <= slot_end ? '0 : tcnt + TW'(1);
      if (slot_end) begin
        fir_r <= 1'b1;
        if (at_last) begin
          slot_r <= '0;
          fs_r   <= 1'b1;
          alt_r  <= pend;
          pend   <= req_rise;
          chop_r <= chop_r ^ chop_en;
        end else begin
          slot_r <= slot_r + SW'(1);
        end
      end
    end
  end

  assign sel_code    = (alt_r && !keep_n) ? code_a : code_n;
  assign slot_idx    = slot_r + SW'(1);
  assign alt_frame   = alt_r;
  assign frame_start = fs_r;
  assign fir_start   = fir_r;
  assign chop_phase  = chop_r;
  assign bat_en      = bat_mon_en && (sel_code == BAT_CODE);
endmodule

// File: rtl/mux_frame_seq_chk.sv
module mux_frame_seq_chk #(
  parameter int NSLOT = 10,
  parameter int CODE_W = 4,
  parameter logic [2**CODE_W-1:0] VOLT_MASK = 16'h002A,
  localparam int SW = $clog2(NSLOT+1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    bat_mon_en,
  input logic [NSLOT*CODE_W-1:0] norm_sel,
  input logic [CODE_W-1:0]       sel_code,
  input logic [SW-1:0]           slot_idx,
  input logic                    alt_frame,
  input logic                    frame_start,
  input logic                    fir_start,
  input logic                    chop_phase,
  input logic                    bat_en
);
  logic [CODE_W-1:0] nsel [NSLOT];
  for (genvar i = 0; i < NSLOT; i++) begin : g_n
    assign nsel[i] = norm_sel[i*CODE_W +: CODE_W];
  end
  wire [SW-1:0] ix = slot_idx - SW'(1);
  wire [CODE_W-1:0] ncode = nsel[ix];

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx >= SW'(1)) && (slot_idx <= SW'(NSLOT)));
  // R7
  frame_start_slot_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_idx == SW'(1)) && fir_start);
  // R7
  fir_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fir_start |-> $past(tick));
  // R10
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot_idx) && $stable(alt_frame) && !fir_start);
  // R4
  alt_change_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_frame != $past(alt_frame)) |-> frame_start);
  // R8
  chop_change_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_phase != $past(chop_phase)) |-> frame_start);
  // R6
  volt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    VOLT_MASK[ncode] |-> (sel_code == ncode));
  // R9
  bat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_en |-> bat_mon_en);
endmodule

bind mux_frame_seq mux_frame_seq_chk #(
  .NSLOT(NSLOT), .CODE_W(CODE_W), .VOLT_MASK(VOLT_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bat_mon_en(bat_mon_en),
  .norm_sel(norm_sel), .sel_code(sel_code), .slot_idx(slot_idx),
  .alt_frame(alt_frame), .frame_start(frame_start), .fir_start(fir_start),
  .chop_phase(chop_phase), .bat_en(bat_en)
);

// File: tb/mux_frame_seq_test.sv
module mux_frame_seq_test;
  localparam int TPS = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0] slot_count = 4'd3;
  logic [39:0] norm_sel = '0, alt_sel = '0;
  logic alt_req = 1'b0, chop_en = 1'b0, bat_mon_en = 1'b0;
  logic [3:0] sel_code, slot_idx;
  logic alt_frame, frame_start, fir_start, chop_phase, bat_en;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mux_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot_count(slot_count),
    .norm_sel(norm_sel), .alt_sel(alt_sel), .alt_req(alt_req),
    .chop_en(chop_en), .bat_mon_en(bat_mon_en), .sel_code(sel_code),
    .slot_idx(slot_idx), .alt_frame(alt_frame), .frame_start(frame_start),
    .fir_start(fir_start), .chop_phase(chop_phase), .bat_en(bat_en)
  );

  function automatic logic [39:0] pack3(int c1, int c2, int c3);
    return {28'd0, 4'(c3), 4'(c2), 4'(c1)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; alt_req = 1'b0; chop_en = 1'b0; bat_mon_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic adv();
    repeat (TPS) do_tick();
  endtask

  task automatic pulse_req(input int len);
    @(negedge clk) alt_req = 1'b1;
    repeat (len) @(negedge clk);
    alt_req = 1'b0;
  endtask

  task automatic t_reset();
    norm_sel = pack3(6, 2, 3);
    slot_count = 4'd3;
    do_reset();
    check("R11 slot", slot_idx, 1);
    check("R11 alt_frame", alt_frame, 0);
    check("R11 chop", chop_phase, 0);
    check("R11 frame_start", frame_start, 0);
    check("R11 fir_start", fir_start, 0);
    check("R3 sel normal", sel_code, 6);
  endtask

  task automatic t_ticks();
    norm_sel = pack3(0, 2, 3);
    slot_count = 4'd3;
    do_reset();
    repeat (TPS-1) do_tick();
    check("R2 no advance before 4 ticks", slot_idx, 1);
    check("R7 no fir yet", fir_start, 0);
    do_tick();
    check("R2 slot 2", slot_idx, 2);
    check("R7 fir on slot change", fir_start, 1);
    check("R7 no frame_start mid frame", frame_start, 0);
    check("R3 sel slot2", sel_code, 2);
    repeat (20) @(negedge clk);
    check("R10 slot held", slot_idx, 2);
    check("R10 fir low", fir_start, 0);
    adv();
    check("R2 slot 3", slot_idx, 3);
    adv();
    check("R2 wrap to 1", slot_idx, 1);
    check("R7 frame_start at wrap", frame_start, 1);
    check("R7 fir at wrap", fir_start, 1);
    @(negedge clk);
    check("R7 frame_start one cycle", frame_start, 0);
  endtask

  task automatic t_counts();
    slot_count = 4'd0;
    do_reset();
    adv();
    check("R1 count0 wraps", slot_idx, 1);
    check("R1 count0 frame_start", frame_start, 1);
    slot_count = 4'd15;
    for (int k = 2; k <= 10; k++) begin
      adv();
      check("R1 count15 slot", slot_idx, k);
    end
    adv();
    check("R1 count15 wraps after 10", slot_idx, 1);
    check("R1 count15 frame_start", frame_start, 1);
  endtask

  task automatic t_alt();
    norm_sel = pack3(0, 2, 3);
    alt_sel  = pack3(8, 9, 12);
    slot_count = 4'd3;
    do_reset();
    adv();
    pulse_req(1);
    check("R4 no change mid frame", alt_frame, 0);
    check("R4 sel stays normal", sel_code, 2);
    adv();
    check("R4 still normal slot3", alt_frame, 0);
    adv();
    check("R4 alt frame begins", alt_frame, 1);
    check("R3 alt code slot1", sel_code, 8);
    adv();
    check("R3 alt code slot2", sel_code, 9);
    check("R9 bat gated off", bat_en, 0);
    @(negedge clk) bat_mon_en = 1'b1;
    #1;
    check("R9 bat enabled", bat_en, 1);
    adv();
    check("R6 voltage slot kept", sel_code, 3);
    check("R9 bat low other code", bat_en, 0);
    adv();
    check("R4 back to normal", alt_frame, 0);
    check("R4 normal code again", sel_code, 0);
  endtask

  task automatic t_queue();
    norm_sel = pack3(0, 2, 3);
    alt_sel  = pack3(8, 9, 12);
    slot_count = 4'd2;
    do_reset();
    pulse_req(1);
    adv(); adv();
    check("R4 first alt frame", alt_frame, 1);
    pulse_req(3);
    adv(); adv();
    check("R5 queued alt frame", alt_frame, 1);
    check("R5 queued frame_start", frame_start, 1);
    adv(); adv();
    check("R5 only one extra", alt_frame, 0);
    @(negedge clk) alt_req = 1'b1;
    adv(); adv();
    check("R4 held request one alt", alt_frame, 1);
    adv(); adv();
    check("R4 held request then normal", alt_frame, 0);
    alt_req = 1'b0;
  endtask

  task automatic t_chop();
    slot_count = 4'd1;
    do_reset();
    chop_en = 1'b1;
    adv();
    check("R8 toggle 1", chop_phase, 1);
    adv();
    check("R8 toggle 2", chop_phase, 0);
    adv();
    check("R8 toggle 3", chop_phase, 1);
    chop_en = 1'b0;
    adv();
    check("R8 hold when disabled", chop_phase, 1);
    adv();
    check("R8 hold again", chop_phase, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_ticks();
    t_counts();
    t_alt();
    t_queue();
    t_chop();
    finish_run();
  end
endmodule